// File: doc/BRIEF.md
# ISA Bus Cycle Master

This block turns single host requests into legacy ISA bus cycles. A request gives a 24-bit address, 16-bit write data, a read/write flag, a memory/I-O flag and a byte/word width. It is taken in only while the block is idle. The block then runs one or two byte-lane cycles on the bus and returns the assembled read data to the host. Every bus cycle has the same shape: a one-clock address latch enable pulse, a command strobe held low for a fixed number of clocks, and one idle clock.

The sequencer has four states. **IDLE** waits for a request. **ALE** drives the address latch enable pulse. **STB** holds the command strobe. **GAP** is the recovery clock. The transitions are:
- IDLE→ALE when a request is accepted.
- ALE→STB after one clock.
- STB→GAP when the strobe counter reaches its last count.
- GAP→ALE when a split second byte cycle is still pending.
- GAP→IDLE otherwise, which also completes the transfer.

A word request first runs as a 16-bit cycle. If the target does not assert the 16-bit acknowledge during the last strobe clock, the block repeats the access at address+1 and moves the upper byte over the low lane. The system memory strobes are qualified by the 1 MB boundary, taken from address bits 23:20.

Top module: `isa_cycle_master`

## Requirements
- R1: Each bus cycle starts with `bale` high for exactly one clock, with `sa` and `sbhe_n` already valid. Both stay unchanged for the rest of that cycle (STB and GAP clocks).
- R2: The command strobe is low for exactly 4 consecutive clocks, starting the clock after `bale`. It is followed by one clock with every strobe high.
- R3: `memr_n` / `memw_n` go low for every memory read / write, and `ior_n` / `iow_n` go low for every I/O read / write. At most one of these four is low at any time.
- R4: `smemr_n` / `smemw_n` follow `memr_n` / `memw_n` only when address bits 23:20 of the current cycle are zero. Otherwise they stay high.
- R5: In I/O cycles `sa[19:16]` is zero and `sa[15:0]` carries the address. An I/O address+1 wraps within 16 bits.
- R6: A word request's first cycle has `sbhe_n` low and drives the full word on `sd_out`. If `tgt_wide_n` is low during the last strobe clock, the transfer ends after that cycle and a read returns all 16 bits of `sd_in`.
- R7: Without that acknowledge, a second cycle follows at address+1 with `sbhe_n` high. It puts `{8'h00, wdata[15:8]}` on `sd_out`. A read returns `{second sd_in[7:0], first sd_in[7:0]}`.
- R8: A byte request runs one cycle with `sbhe_n` high and `{8'h00, wdata[7:0]}` on `sd_out`. A read returns `{8'h00, sd_in[7:0]}`.
- R9: `aen` is always low.
- R10: Read data is captured from `sd_in` in the last strobe clock and is visible on `rdata` from the following GAP clock. Writes leave `rdata` unchanged.
- R11: `sd_oe` is high only while a write strobe is low, and never during reads.
- R12: `busy` is high from the ALE clock through the final GAP clock. `done` is high for exactly the final GAP clock. A `req_valid` seen while busy is ignored.
- R13: After reset all strobes and `sbhe_n` are high, and `bale`, `busy`, `done`, `sd_oe` and `rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; accepted while idle |
| req_addr | input | 24 | Request address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_wide | input | 1 | 1 = 16-bit request, 0 = byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Assembled read data |
| bale | output | 1 | Address latch enable pulse |
| sa | output | 20 | Bus address |
| sbhe_n | output | 1 | Upper byte lane enable, active low |
| aen | output | 1 | DMA cycle flag (held low) |
| memr_n | output | 1 | Memory read strobe |
| memw_n | output | 1 | Memory write strobe |
| smemr_n | output | 1 | Memory read strobe below 1 MB |
| smemw_n | output | 1 | Memory write strobe below 1 MB |
| ior_n | output | 1 | I/O read strobe |
| iow_n | output | 1 | I/O write strobe |
| tgt_wide_n | input | 1 | Target 16-bit acknowledge, active low |
| sd_in | input | 16 | Data bus input |
| sd_out | output | 16 | Data bus output value |
| sd_oe | output | 1 | Data bus output enable |

## Verification
Every bus output is decoded directly from the state register and the latched request, so a wrong state shows at the ports in the same clock. Examples are a strobe that lasts three or five clocks, a missing recovery clock, a `bale` inside a strobe, or `done` on the first half of a split transfer. A wrong split decision or a wrong latched byte lane shows one cycle later, as a second ALE that is missing or extra, a wrong address+1, or misplaced bytes in `rdata`. The bench predicts every output on every clock across:
- byte, acknowledged-word and split-word transfers;
- both address spaces;
- the 1 MB crossing in the middle of a split;
- the 16-bit I/O wrap;
- requests held high while the block is busy.

// File: rtl/isa_cm_pkg.sv
package isa_cm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ALE,
        ST_STB,
        ST_GAP
    } isa_state_e;

endpackage

// File: rtl/isa_cm_seq.sv
module isa_cm_seq
    import isa_cm_pkg::*;
#(
    parameter int unsigned STB_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_wide,
    input  logic       tgt_wide_n,
    output isa_state_e state_o,
    output logic       load_o,
    output logic       step_o,
    output logic       cap_o,
    output logic       second_o,
    output logic       bale_o,
    output logic       strobe_on_o,
    output logic       busy_o,
    output logic       done_o
);

    localparam int unsigned CNT_W = (STB_CLKS > 1) ? $clog2(STB_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STB_CLKS - 1);

    isa_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             wide_q;
    logic             split_q;
    logic             second_q;
    logic             more;

    assign more = split_q && !second_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_ALE;
            ST_ALE:  state_d = ST_STB;
            ST_STB:  if (cnt_q == LAST) state_d = ST_GAP;
            ST_GAP:  state_d = more ? ST_ALE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and its companions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            wide_q   <= 1'b0;
            split_q  <= 1'b0;
            second_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ALE) cnt_q <= '0;
            else if (state_q == ST_STB) cnt_q <= cnt_q + CNT_W'(1);
            if (load_o) begin
                wide_q   <= req_wide;
                split_q  <= 1'b0;
                second_q <= 1'b0;
            end
            if (cap_o && !second_q) split_q <= wide_q && tgt_wide_n;
            if (step_o) second_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        load_o      = (state_q == ST_IDLE) && req_valid;
        step_o      = (state_q == ST_GAP) && more;
        cap_o       = (state_q == ST_STB) && (cnt_q == LAST);
        second_o    = second_q;
        bale_o      = (state_q == ST_ALE);
        strobe_on_o = (state_q == ST_STB);
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_GAP) && !more;
        state_o     = state_q;
    end

    p_bale_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bale_o |=> (!bale_o && strobe_on_o));
    p_stb_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_on_o && cnt_q != LAST) |=> strobe_on_o);
    p_stb_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_o |=> (!strobe_on_o && !bale_o));
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);
    p_no_accept_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && !step_o) |=> busy_o);

endmodule

// File: rtl/isa_cm_lane.sv
module isa_cm_lane #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned SA_W   = 20,
    parameter int unsigned IO_W   = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              cap,
    input  logic              second,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_io,
    input  logic              req_wide,
    input  logic              tgt_wide_n,
    input  logic [DATA_W-1:0] sd_in,
    output logic [SA_W-1:0]   sa_o,
    output logic              below_1m_o,
    output logic              sbhe_n_o,
    output logic [DATA_W-1:0] sd_out_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              write_o,
    output logic              io_o
);

    localparam int unsigned BYTE_W = DATA_W / 2;
    localparam int unsigned HI_W   = ADDR_W - IO_W;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              write_q, io_q, wide_q;
    logic [IO_W-1:0]   io_next;

    assign io_next = addr_q[IO_W-1:0] + IO_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            write_q <= 1'b0;
            io_q    <= 1'b0;
            wide_q  <= 1'b0;
        end else begin
            if (load) begin
                addr_q  <= req_io ? {{HI_W{1'b0}}, req_addr[IO_W-1:0]} : req_addr;
                wdata_q <= req_wdata;
                write_q <= req_write;
                io_q    <= req_io;
                wide_q  <= req_wide;
            end else if (step) begin
                addr_q <= io_q ? {{HI_W{1'b0}}, io_next} : addr_q + ADDR_W'(1);
            end
            if (cap && !write_q) begin
                if (second)
                    rdata_q[DATA_W-1:BYTE_W] <= sd_in[BYTE_W-1:0];
                else if (wide_q && !tgt_wide_n)
                    rdata_q <= sd_in;
                else
                    rdata_q <= {{BYTE_W{1'b0}}, sd_in[BYTE_W-1:0]};
            end
        end
    end

    always_comb begin
        sa_o       = addr_q[SA_W-1:0];
        below_1m_o = ~|addr_q[ADDR_W-1:SA_W];
        sbhe_n_o   = !(wide_q && !second);
        if (second)
            sd_out_o = {{BYTE_W{1'b0}}, wdata_q[DATA_W-1:BYTE_W]};
        else if (wide_q)
            sd_out_o = wdata_q;
        else
            sd_out_o = {{BYTE_W{1'b0}}, wdata_q[BYTE_W-1:0]};
        rdata_o = rdata_q;
        write_o = write_q;
        io_o    = io_q;
    end

    p_second_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (sbhe_n_o && sd_out_o[DATA_W-1:BYTE_W] == '0));
    p_write_keeps_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && write_q) |=> $stable(rdata_o));

endmodule

// File: rtl/isa_cm_strobe.sv
module isa_cm_strobe (
    input  logic strobe_on,
    input  logic write,
    input  logic io,
    input  logic below_1m,
    output logic memr_n,
    output logic memw_n,
    output logic smemr_n,
    output logic smemw_n,
    output logic ior_n,
    output logic iow_n,
    output logic sd_oe
);

    logic mem_rd, mem_wr;

    always_comb begin
        mem_rd  = strobe_on && !io && !write;
        mem_wr  = strobe_on && !io && write;
        memr_n  = !mem_rd;
        memw_n  = !mem_wr;
        smemr_n = !(mem_rd && below_1m);
        smemw_n = !(mem_wr && below_1m);
        ior_n   = !(strobe_on && io && !write);
        iow_n   = !(strobe_on && io && write);
        sd_oe   = strobe_on && write;
    end

    always_comb begin
        a_smem_pair_r4: assert (smemr_n || !memr_n);
    end

endmodule

// File: rtl/isa_cycle_master.sv
module isa_cycle_master
    import isa_cm_pkg::*;
#(
    parameter int unsigned ADDR_W   = 24,
    parameter int unsigned SA_W     = 20,
    parameter int unsigned IO_W     = 16,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned STB_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_io,
    input  logic              req_wide,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bale,
    output logic [SA_W-1:0]   sa,
    output logic              sbhe_n,
    output logic              aen,
    output logic              memr_n,
    output logic              memw_n,
    output logic              smemr_n,
    output logic              smemw_n,
    output logic              ior_n,
    output logic              iow_n,
    input  logic              tgt_wide_n,
    input  logic [DATA_W-1:0] sd_in,
    output logic [DATA_W-1:0] sd_out,
    output logic              sd_oe
);

    isa_state_e state;
    logic load, step, cap, second, strobe_on;
    logic below_1m, write_q, io_q;

    isa_cm_seq #(.STB_CLKS(STB_CLKS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_wide    (req_wide),
        .tgt_wide_n  (tgt_wide_n),
        .state_o     (state),
        .load_o      (load),
        .step_o      (step),
        .cap_o       (cap),
        .second_o    (second),
        .bale_o      (bale),
        .strobe_on_o (strobe_on),
        .busy_o      (busy),
        .done_o      (done)
    );

    isa_cm_lane #(
        .ADDR_W (ADDR_W),
        .SA_W   (SA_W),
        .IO_W   (IO_W),
        .DATA_W (DATA_W)
    ) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .cap        (cap),
        .second     (second),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_write  (req_write),
        .req_io     (req_io),
        .req_wide   (req_wide),
        .tgt_wide_n (tgt_wide_n),
        .sd_in      (sd_in),
        .sa_o       (sa),
        .below_1m_o (below_1m),
        .sbhe_n_o   (sbhe_n),
        .sd_out_o   (sd_out),
        .rdata_o    (rdata),
        .write_o    (write_q),
        .io_o       (io_q)
    );

    isa_cm_strobe u_strobe (
        .strobe_on (strobe_on),
        .write     (write_q),
        .io        (io_q),
        .below_1m  (below_1m),
        .memr_n    (memr_n),
        .memw_n    (memw_n),
        .smemr_n   (smemr_n),
        .smemw_n   (smemw_n),
        .ior_n     (ior_n),
        .iow_n     (iow_n),
        .sd_oe     (sd_oe)
    );

    // only CPU-style cycles are generated
    assign aen = 1'b0;

    p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bale) |-> ($stable(sa) && $stable(sbhe_n)));
    p_one_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~memr_n, ~memw_n, ~ior_n, ~iow_n}) <= 1);
    p_smem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!smemr_n || !smemw_n) |-> below_1m);
    p_io_high_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ior_n || !iow_n) |-> (sa[SA_W-1:IO_W] == '0));
    p_oe_write_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> (!memw_n || !iow_n));
    p_no_bale_in_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bale |-> (memr_n && memw_n && ior_n && iow_n));
    p_state_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !busy);

endmodule

// File: tb/isa_cycle_master_tb.sv
module isa_cycle_master_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_write = 1'b0, req_io = 1'b0, req_wide = 1'b0;
    logic        busy, done, bale, sbhe_n, aen;
    logic        memr_n, memw_n, smemr_n, smemw_n, ior_n, iow_n, sd_oe;
    logic [15:0] rdata, sd_out;
    logic [19:0] sa;
    logic        tgt_wide_n = 1'b1;
    logic [15:0] sd_in = '0;

    int total = 0;
    int bad = 0;
    logic [15:0] mdl_rdata = '0;

    always #5 clk = ~clk;

    isa_cycle_master u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
        .req_wide(req_wide), .busy(busy), .done(done), .rdata(rdata),
        .bale(bale), .sa(sa), .sbhe_n(sbhe_n), .aen(aen), .memr_n(memr_n),
        .memw_n(memw_n), .smemr_n(smemr_n), .smemw_n(smemw_n), .ior_n(ior_n),
        .iow_n(iow_n), .tgt_wide_n(tgt_wide_n), .sd_in(sd_in),
        .sd_out(sd_out), .sd_oe(sd_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // {memr, memw, smemr, smemw, ior, iow}, active low
    function automatic logic [5:0] exp_cmd(input bit on, input bit wr, input bit io,
                                           input logic [23:0] a);
        bit lo = (a[23:20] == 4'h0);
        exp_cmd = ~{on && !io && !wr, on && !io && wr,
                    on && !io && !wr && lo, on && !io && wr && lo,
                    on && io && !wr, on && io && wr};
    endfunction

    function automatic logic [5:0] act_cmd();
        act_cmd = {memr_n, memw_n, smemr_n, smemw_n, ior_n, iow_n};
    endfunction

    task automatic chk_idle(input string tag);
        chk({tag, " R12 busy idle"}, busy, 0);
        chk({tag, " R1 bale idle"}, bale, 0);
        chk({tag, " R2 strobes idle"}, act_cmd(), 6'h3F);
        chk({tag, " R11 oe idle"}, sd_oe, 0);
        chk({tag, " R9 aen"}, aen, 0);
        chk({tag, " R10 rdata idle"}, rdata, mdl_rdata);
    endtask

    // runs one request and predicts every clock; entered right after a negedge
    task automatic run_req(input string tag, input logic [23:0] a, input logic [15:0] wd,
                           input bit wr, input bit io, input bit wide, input bit ack,
                           input logic [15:0] da, input logic [15:0] db, input bit hold);
        int ncyc = (wide && !ack) ? 2 : 1;
        logic [23:0] cur = io ? {8'h00, a[15:0]} : a;
        req_valid = 1'b1; req_addr = a; req_wdata = wd;
        req_write = wr; req_io = io; req_wide = wide;
        for (int n = 0; n < ncyc; n++) begin
            bit last = (n == ncyc - 1);
            logic [15:0] exp_out;
            bit exp_sbhe;
            if (n == 1) cur = io ? {8'h00, cur[15:0] + 16'h1} : cur + 24'h1;
            exp_sbhe = !(wide && n == 0);
            exp_out  = (n == 1) ? {8'h00, wd[15:8]} : (wide ? wd : {8'h00, wd[7:0]});
            @(negedge clk);
            // ALE clock
            if (hold) begin
                req_addr = ~a; req_wdata = ~wd; req_wide = ~wide; req_write = ~wr;
            end else req_valid = 1'b0;
            sd_in = (n == 0) ? da : db;
            tgt_wide_n = !ack;
            chk({tag, " R1 bale"}, bale, 1);
            chk({tag, " R1 R5 sa"}, sa, cur[19:0]);
            chk({tag, " R6 R7 R8 sbhe_n"}, sbhe_n, exp_sbhe);
            chk({tag, " R9 aen"}, aen, 0);
            chk({tag, " R2 no strobe in ale"}, act_cmd(), 6'h3F);
            chk({tag, " R12 busy"}, busy, 1);
            chk({tag, " R12 done"}, done, 0);
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                chk({tag, " R2 R3 R4 strobes"}, act_cmd(), exp_cmd(1, wr, io, cur));
                chk({tag, " R1 bale low"}, bale, 0);
                chk({tag, " R1 sa held"}, sa, cur[19:0]);
                chk({tag, " R1 sbhe held"}, sbhe_n, exp_sbhe);
                chk({tag, " R11 oe"}, sd_oe, wr);
                if (wr) chk({tag, " R6 R7 R8 sd_out"}, sd_out, exp_out);
                chk({tag, " R12 busy stb"}, busy, 1);
            end
            @(negedge clk);
            // GAP clock
            if (!wr) begin
                if (n == 1) mdl_rdata[15:8] = db[7:0];
                else if (wide && ack) mdl_rdata = da;
                else mdl_rdata = {8'h00, da[7:0]};
            end
            if (last) req_valid = 1'b0;
            chk({tag, " R2 gap strobes"}, act_cmd(), 6'h3F);
            chk({tag, " R2 gap bale"}, bale, 0);
            chk({tag, " R11 gap oe"}, sd_oe, 0);
            chk({tag, " R1 gap sa"}, sa, cur[19:0]);
            chk({tag, " R12 gap done"}, done, last);
            chk({tag, " R12 gap busy"}, busy, 1);
            chk({tag, " R10 R7 rdata"}, rdata, mdl_rdata);
        end
        @(negedge clk);
        chk_idle(tag);
        sd_in = 16'h0; tgt_wide_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 strobes", act_cmd(), 6'h3F);
        chk("R13 sbhe_n", sbhe_n, 1);
        chk("R13 bale", bale, 0);
        chk("R13 busy", busy, 0);
        chk("R13 done", done, 0);
        chk("R13 sd_oe", sd_oe, 0);
        chk("R13 rdata", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R13 post");

        run_req("R8 mem byte rd", 24'h001234, 16'h0, 0, 0, 0, 0, 16'h55AA, 16'h0, 0);
        run_req("R4 byte wr >1M", 24'h234567, 16'hFFC3, 1, 0, 0, 0, 16'h0, 16'h0, 0);
        run_req("R5 io byte wr", 24'h0503F8, 16'h0077, 1, 1, 0, 0, 16'h0, 16'h0, 0);
        run_req("R6 io word rd ack", 24'h000300, 16'h0, 0, 1, 1, 1, 16'hBEEF, 16'h0, 0);
        run_req("R7 R4 split rd 1M cross", 24'h0FFFFF, 16'h0, 0, 0, 1, 0,
                16'h1122, 16'h3344, 0);
        run_req("R7 split wr", 24'h008000, 16'h1234, 1, 0, 1, 0, 16'h0, 16'h0, 0);
        run_req("R6 io word wr ack", 24'h000060, 16'hA5C3, 1, 1, 1, 1, 16'h0, 16'h0, 0);
        run_req("R5 R7 io split wrap", 24'h00FFFF, 16'h0, 0, 1, 1, 0,
                16'h00AB, 16'h00CD, 0);
        run_req("R12 hold while busy", 24'h0A0010, 16'h0, 0, 0, 0, 0, 16'h9966, 16'h0, 1);
        run_req("R12 hold split", 24'h300002, 16'hC0DE, 1, 0, 1, 0, 16'h0, 16'h0, 1);
        run_req("R6 mem word rd ack >1M", 24'hF00000, 16'h0, 0, 0, 1, 1, 16'h7E81, 16'h0, 0);
        run_req("R10 write keeps rdata", 24'h000010, 16'h4242, 1, 0, 0, 0, 16'hFFFF, 16'h0, 0);
        repeat (2) begin
            @(negedge clk);
            chk_idle("R12 final idle");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R12 actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule